// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable logic array. It receives a sum-of-products term that is already formed and turns it into a pad output. Static configuration inputs decide how that happens. The result can be stored in a flip-flop or passed straight through. The flip-flop can load the term (D behaviour) or toggle on it (T behaviour). The flip-flop clock is picked from a small bus of clocks. The value sent to the pad can be inverted.

The cell also drives the pad enable from an output-enable term and returns two feedback signals:
- an internal feedback of the true-polarity logic result;
- a pad feedback, which either follows the pad input directly or comes through an optional capture register on the same selected clock.

A block-wide asynchronous clear and a block-wide asynchronous set let every cell of a block initialise together. The clear wins when both are asserted.

Configuration inputs may change only while every clock on the bus is low.

Top module: `macrocell_cfg`

## Requirements
- R1: With `cfg_registered`=0, `pad_out` equals `sum_in` XOR `cfg_invert` combinationally, with no clock needed.
- R2: With `cfg_registered`=1 and `cfg_toggle`=0, the stored bit takes the value of `sum_in` on each rising edge of the selected clock.
- R3: With `cfg_registered`=1 and `cfg_toggle`=1, the stored bit inverts on a rising edge of the selected clock when `sum_in`=1 and holds when `sum_in`=0.
- R4: `cfg_clk_sel`=k selects `clk_bus[k]` (bit 0 is clock 0). Edges on the other clocks, and all falling edges, leave the stored bit and the capture register unchanged.
- R5: In registered mode `pad_out` equals the stored bit XOR `cfg_invert`, while `fb_int` always carries the stored bit in true polarity.
- R6: `bank_rst`=1 clears the stored bit and the capture register at once, without any clock edge.
- R7: `bank_pre`=1 with `bank_rst`=0 sets the stored bit to 1 at once and keeps it at 1 across clock edges.
- R8: When `bank_rst` and `bank_pre` are both 1, the stored bit is 0.
- R9: `pad_oe` follows `oe_term` combinationally in every mode.
- R10: With `cfg_in_reg`=0, `fb_pad` follows `pad_in` combinationally.
- R11: With `cfg_in_reg`=1, `fb_pad` shows `pad_in` as captured on the last rising edge of the selected clock. This capture register is cleared by `bank_rst` and is not affected by `bank_pre`.
- R12: With `cfg_registered`=0, `fb_int` follows `sum_in` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | NUM_CLK | Clocks from which the cell picks one |
| cfg_clk_sel | input | SEL_W | Index of the clock used by the flip-flop and capture register |
| cfg_registered | input | 1 | 1: registered result, 0: combinational result |
| cfg_toggle | input | 1 | 1: T behaviour, 0: D behaviour |
| cfg_invert | input | 1 | 1: invert the value sent to the pad |
| cfg_in_reg | input | 1 | 1: pad feedback through the capture register |
| sum_in | input | 1 | Sum-of-products term |
| bank_rst | input | 1 | Block-wide asynchronous clear, active high |
| bank_pre | input | 1 | Block-wide asynchronous set, active high |
| oe_term | input | 1 | Output-enable term |
| pad_in | input | 1 | Value present at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_int | output | 1 | Internal feedback, true polarity |
| fb_pad | output | 1 | Pad feedback |

## Verification
The bench raises selected clock-bus bits on the rising edge of its own clock and lowers them all at the falling edge. A registered result is therefore due half a bench period after the stimulus, and it is compared at that falling edge against a behavioural model that is advanced at the same rising edge. Combinational results (R1, R9, R10, R12) and the asynchronous clear and set (R6, R7, R8) need no clock. They are compared 1 ns after the inputs change, before any clock pulse follows. Clear and set pulses are held across a clock edge, so the model's priority between them and the clock is also exercised.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    // static configuration of one cell, gathered from the top-level pins
    typedef struct packed {
        logic registered;
        logic toggle;
        logic invert;
        logic in_reg;
    } mcell_cfg_t;

    // state of the storage flip-flop
    typedef struct packed {
        logic bit_v;
    } store_st_t;

    // state of the pad capture register
    typedef struct packed {
        logic cap;
    } cap_st_t;

endpackage

// File: rtl/mcell_clksel.sv
module mcell_clksel #(
    parameter int NUM_CLK = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_CLK-1:0] clk_bus,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_o
);

    generate
        if (NUM_CLK == 1) begin : g_single
            logic unused_sel;
            assign unused_sel = ^sel;
            assign clk_o = clk_bus[0];
        end else begin : g_mux
            // out-of-range select values give a quiet clock
            always_comb begin
                clk_o = 1'b0;
                for (int i = 0; i < NUM_CLK; i++) begin
                    if (sel == SEL_W'(i)) begin
                        clk_o = clk_bus[i];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mcell_store.sv
module mcell_store
    import mcell_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic aset,
    input  logic toggle,
    input  logic sum_in,
    output logic q
);

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (toggle) begin
            st_d.bit_v = st_q.bit_v ^ sum_in;
        end else begin
            st_d.bit_v = sum_in;
        end
    end

    // clear has priority over set
    always_ff @(posedge clk or posedge arst or posedge aset) begin
        if (arst) begin
            st_q <= '0;
        end else if (aset) begin
            st_q.bit_v <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.bit_v;

endmodule

// File: rtl/mcell_padreg.sv
module mcell_padreg
    import mcell_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic enable,
    input  logic pad_in,
    output logic fb_pad
);

    cap_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cap = pad_in;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fb_pad = enable ? st_q.cap : pad_in;

endmodule

// File: rtl/macrocell_cfg.sv
module macrocell_cfg
    import mcell_pkg::*;
#(
    parameter  int NUM_CLK    = 4,
    parameter  bit HAS_IN_REG = 1'b1,
    localparam int SEL_W      = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clk_bus,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic               cfg_registered,
    input  logic               cfg_toggle,
    input  logic               cfg_invert,
    input  logic               cfg_in_reg,
    input  logic               sum_in,
    input  logic               bank_rst,
    input  logic               bank_pre,
    input  logic               oe_term,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               fb_int,
    output logic               fb_pad
);

    mcell_cfg_t cfg;
    logic       sel_clk;
    logic       stored;
    logic       result;

    assign cfg = '{registered: cfg_registered, toggle: cfg_toggle,
                   invert: cfg_invert, in_reg: cfg_in_reg};

    mcell_clksel #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_clksel (
        .clk_bus (clk_bus),
        .sel     (cfg_clk_sel),
        .clk_o   (sel_clk)
    );

    mcell_store u_store (
        .clk    (sel_clk),
        .arst   (bank_rst),
        .aset   (bank_pre),
        .toggle (cfg.toggle),
        .sum_in (sum_in),
        .q      (stored)
    );

    assign result  = cfg.registered ? stored : sum_in;
    assign fb_int  = result;
    assign pad_out = result ^ cfg.invert;
    assign pad_oe  = oe_term;

    generate
        if (HAS_IN_REG) begin : g_inreg
            mcell_padreg u_padreg (
                .clk    (sel_clk),
                .arst   (bank_rst),
                .enable (cfg.in_reg),
                .pad_in (pad_in),
                .fb_pad (fb_pad)
            );
        end else begin : g_noinreg
            assign fb_pad = pad_in;
        end
    endgenerate

endmodule

// File: rtl/mcell_chk.sv
module mcell_chk (
    input logic sel_clk,
    input logic cfg_registered,
    input logic cfg_toggle,
    input logic cfg_invert,
    input logic cfg_in_reg,
    input logic sum_in,
    input logic bank_rst,
    input logic bank_pre,
    input logic pad_in,
    input logic pad_out,
    input logic fb_int,
    input logic fb_pad
);

    AST_COMB_POL: assert property (@(posedge sel_clk) disable iff (bank_rst)
        !cfg_registered |-> (pad_out == (sum_in ^ cfg_invert))); // R1

    AST_D_LOAD: assert property (@(posedge sel_clk) disable iff (bank_rst || bank_pre)
        (cfg_registered && !cfg_toggle) |=>
        (!$stable(cfg_registered) || !$stable(cfg_toggle) || fb_int == $past(sum_in))); // R2

    AST_T_FLIP: assert property (@(posedge sel_clk) disable iff (bank_rst || bank_pre)
        (cfg_registered && cfg_toggle) |=>
        (!$stable(cfg_registered) || !$stable(cfg_toggle) ||
         fb_int == ($past(fb_int) ^ $past(sum_in)))); // R3

    AST_CLEAR_WINS: assert property (@(posedge sel_clk) disable iff (!cfg_registered)
        bank_rst |-> !fb_int); // R8

    AST_SET_HOLDS: assert property (@(posedge sel_clk) disable iff (bank_rst)
        (bank_pre && cfg_registered) |-> fb_int); // R7

    AST_IN_CAPTURE: assert property (@(posedge sel_clk) disable iff (bank_rst)
        cfg_in_reg |=> (!$stable(cfg_in_reg) || fb_pad == $past(pad_in))); // R11

endmodule

bind macrocell_cfg mcell_chk u_chk (
    .sel_clk        (sel_clk),
    .cfg_registered (cfg_registered),
    .cfg_toggle     (cfg_toggle),
    .cfg_invert     (cfg_invert),
    .cfg_in_reg     (cfg_in_reg),
    .sum_in         (sum_in),
    .bank_rst       (bank_rst),
    .bank_pre       (bank_pre),
    .pad_in         (pad_in),
    .pad_out        (pad_out),
    .fb_int         (fb_int),
    .fb_pad         (fb_pad)
);

// File: tb/tb_macrocell_cfg.sv
`timescale 1ns/1ps
module tb_macrocell_cfg;

    localparam int NUM_CLK = 4;
    localparam int SEL_W   = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [NUM_CLK-1:0] clk_bus = '0;
    logic [SEL_W-1:0]   cfg_clk_sel = '0;
    logic cfg_registered = 1'b1, cfg_toggle = 1'b0, cfg_invert = 1'b0, cfg_in_reg = 1'b1;
    logic sum_in = 1'b0, bank_rst = 1'b1, bank_pre = 1'b0, oe_term = 1'b0, pad_in = 1'b0;
    logic pad_out, pad_oe, fb_int, fb_pad;

    macrocell_cfg #(.NUM_CLK(NUM_CLK), .HAS_IN_REG(1'b1)) dut (
        .clk_bus(clk_bus), .cfg_clk_sel(cfg_clk_sel), .cfg_registered(cfg_registered),
        .cfg_toggle(cfg_toggle), .cfg_invert(cfg_invert), .cfg_in_reg(cfg_in_reg),
        .sum_in(sum_in), .bank_rst(bank_rst), .bank_pre(bank_pre), .oe_term(oe_term),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_int(fb_int), .fb_pad(fb_pad)
    );

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;
    logic  m_q = 1'b0;     // model of the stored bit
    logic  m_cap = 1'b0;   // model of the capture register
    string tag = "R6";

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic res;
        res = cfg_registered ? m_q : sum_in;
        chk(tag, "pad_out", pad_out, res ^ cfg_invert);
        chk(cfg_registered ? tag : "R12", "fb_int", fb_int, res);
        chk("R9", "pad_oe", pad_oe, oe_term);
        chk(cfg_in_reg ? "R11" : "R10", "fb_pad", fb_pad, cfg_in_reg ? m_cap : pad_in);
    endtask

    // one bench cycle: clock pulses at the rising edge, compare at the falling edge
    task automatic cyc(input logic [NUM_CLK-1:0] mask);
        bit edge_hit;
        @(posedge clk);
        clk_bus  = mask;
        edge_hit = mask[cfg_clk_sel];
        if (bank_rst) m_q = 1'b0;
        else if (bank_pre) m_q = 1'b1;
        else if (edge_hit) m_q = cfg_toggle ? (m_q ^ sum_in) : sum_in;
        if (bank_rst) m_cap = 1'b0;
        else if (edge_hit) m_cap = pad_in;
        @(negedge clk);
        compare_all();
        clk_bus = '0;
    endtask

    task automatic settle();
        #1;
        if (bank_rst) begin m_q = 1'b0; m_cap = 1'b0; end
        else if (bank_pre) m_q = 1'b1;
        compare_all();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // reset state, with edges during reset
        tag = "R6";
        cyc('1);
        cyc('1);
        bank_rst = 1'b0;
        settle();

        // D loading on clock 0
        tag = "R2";
        for (int i = 0; i < 10; i++) begin
            sum_in = i[0] ^ i[2];
            pad_in = i[1];
            cyc(4'b0001);
        end

        // clock selection: only the chosen bit moves the state
        tag = "R4";
        for (int s = 0; s < NUM_CLK; s++) begin
            cfg_clk_sel = SEL_W'(s);
            for (int i = 0; i < 8; i++) begin
                sum_in = ~m_q;
                pad_in = i[0];
                cyc(4'((i * 5 + s * 3) & 15));
            end
        end

        // T behaviour
        tag = "R3";
        cfg_clk_sel = 2'd1;
        cfg_toggle  = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sum_in = (i % 3) != 0;
            cyc(4'b0010);
        end
        cfg_toggle = 1'b0;

        // inverted pad with registered result
        tag = "R5";
        cfg_invert = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sum_in = i[1];
            cyc(4'b0010);
        end

        // combinational path
        tag = "R1";
        cfg_registered = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cfg_invert = i[2];
            sum_in     = i[0];
            settle();
        end

        // enable and pad feedback without capture
        tag = "R1";
        cfg_in_reg = 1'b0;
        for (int i = 0; i < 4; i++) begin
            oe_term = i[0];
            pad_in  = i[1];
            settle();
        end
        cfg_in_reg     = 1'b1;
        cfg_registered = 1'b1;
        cfg_invert     = 1'b0;

        // capture register holds until the selected edge (R11)
        tag = "R2";
        pad_in = ~m_cap;
        settle();
        cyc(4'b1101);
        cyc(4'b0010);

        // asynchronous clear
        sum_in = 1'b1;
        cyc(4'b0010);
        tag = "R6";
        bank_rst = 1'b1;
        settle();
        cyc(4'b0010);
        bank_rst = 1'b0;
        settle();

        // asynchronous set, capture still follows the clock
        tag = "R7";
        sum_in   = 1'b0;
        bank_pre = 1'b1;
        settle();
        pad_in = 1'b1;
        cyc(4'b0010);
        pad_in = 1'b0;
        cyc(4'b0010);
        bank_pre = 1'b0;
        cyc(4'b0010);

        // clear against set
        tag = "R8";
        sum_in   = 1'b1;
        cyc(4'b0010);
        bank_rst = 1'b1;
        bank_pre = 1'b1;
        settle();
        cyc(4'b0010);
        bank_rst = 1'b0;
        bank_pre = 1'b0;
        settle();
        cyc(4'b0010);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule